// File: doc/BRIEF.md
# Per-Task Page Protection Checker

This block decides, for every memory access, whether the active task may perform it. Addresses are identity mapped: no translation happens. Protection is held per 8 KB page in a map that belongs to the running task. Each map entry gives the page an access class, a no-execute flag and a cache-inhibit flag. The block answers each request with allow or fault, plus the page's cache-inhibit flag.

The block keeps a register pointing at the base of the active task's map, and a small fully associative cache of recently used entries. On a miss it reads the entry through a simple map read port and stalls the requester until the entry arrives. At a task switch, software writes the incoming map base. The block keeps the outgoing base visible on a port so that it can be saved, and it empties the entry cache.

A three-state machine controls the request flow:
- IDLE accepts a request (IDLE→LOOK).
- LOOK answers on a cache hit (LOOK→IDLE). On a miss it issues a map read (LOOK→WAIT).
- WAIT holds until map data returns and fills the cache (WAIT→LOOK). LOOK then hits and responds.

Top module: `page_guard`

## Requirements
- R1: Entries of class 0 (private) and class 1 (global) allow reads (kind 0), writes (kind 1) and fetches (kind 2) in both user and supervisor mode, unless R5 applies.
- R2: Class 2 (supervisor-only) faults every user-mode access and allows supervisor accesses.
- R3: Class 3 (private read-only) allows reads and fetches. It faults writes in both modes.
- R4: Class 4 (invalid) and the unused codes 5, 6 and 7 fault every access, supervisor included.
- R5: When the no-execute flag (entry bit 3) is set, a fetch faults whatever the class. Reads and writes follow the class alone.
- R6: The response carries the entry's cache-inhibit flag (entry bit 4), on allowed and on faulting accesses alike.
- R7: The entry format is class in bits 2:0, no-execute in bit 3 and cache-inhibit in bit 4. The entry is read from address root + (address[31:13] × ENTRY_BYTES). The 13 low address bits do not affect which entry is used.
- R8: A root write makes the new value the active root in the next cycle. The previous root is presented on root_prev. Both are 0 after reset.
- R9: A root write invalidates every cached entry. The next access to any page reads the new task's map.
- R10: The cache holds 8 entries. A repeat access to a cached page issues no map read. Misses refill the slots in round-robin order, starting from slot 0 after reset or flush.
- R11: req_ready is high only in IDLE, and is high after reset. On a hit the response comes one cycle after acceptance. On a miss it comes later, after the map read. A map read request is followed by req_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Access byte address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch (3 treated as read) |
| req_super | input | 1 | Access made in supervisor mode |
| resp_valid | output | 1 | Decision valid this cycle |
| resp_fault | output | 1 | Access is refused |
| resp_cinh | output | 1 | Page must not be cached |
| root_wr | input | 1 | Load a new map base (task switch) |
| root_wdata | input | 32 | Incoming map base |
| root_cur | output | 32 | Active map base |
| root_prev | output | 32 | Map base before the last root write |
| map_rd_req | output | 1 | One-cycle map read request |
| map_rd_addr | output | 32 | Map entry address |
| map_rd_valid | input | 1 | Map read data valid |
| map_rd_data | input | 5 | Map entry: cinh, nx, class[2:0] |

## Verification
Assertions check these on every cycle: the write rule for read-only pages, the fetch rule for no-execute pages, the fault rule for invalid codes, and the capture of the outgoing root. They also check that a map read stalls the requester, that a flush is followed by a miss, and that no two cache slots hit at once. Several behaviours show up only in the bench's scenarios. These are the class decisions as seen at the ports, the passing of cache-inhibit, page-offset independence, and a flush being visible as a fault from the new task's map. The count of map reads shows round-robin eviction and hit reuse, and the response latency shows the hit/miss timing.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_FETCH = 2'd2,
        K_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        C_PRIV = 3'd0,
        C_GLOB = 3'd1,
        C_SUPV = 3'd2,
        C_PRRO = 3'd3,
        C_NONE = 3'd4
    } page_cls_e;

    typedef struct packed {
        logic       cinh;
        logic       nx;
        logic [2:0] cls;
    } pte_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOOK = 2'd1,
        S_WAIT = 2'd2
    } pg_state_e;

endpackage

// File: rtl/pg_rule.sv
module pg_rule
    import pg_pkg::*;
(
    input  pte_t       ent,
    input  logic [1:0] kind,
    input  logic       sup,
    output logic       fault
);
    logic cls_fault;

    always_comb begin
        case (ent.cls)
            C_PRIV, C_GLOB: cls_fault = 1'b0;
            C_SUPV:         cls_fault = !sup;
            C_PRRO:         cls_fault = (kind == K_WRITE);
            default:        cls_fault = 1'b1;
        endcase
        fault = cls_fault || ((kind == K_FETCH) && ent.nx);
    end
endmodule

// File: rtl/pg_cache.sv
module pg_cache
    import pg_pkg::*;
#(
    parameter int VPN_W = 19,
    parameter int WAYS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output pte_t             hit_ent,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  pte_t             fill_ent
);
    localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAYS-1:0]  vld;
    logic [VPN_W-1:0] tag [WAYS];
    pte_t             dat [WAYS];
    logic [WAYS-1:0]  hit_vec;
    logic [IDX_W-1:0] rr;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w] = vld[w] && (tag[w] == look_vpn);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[w] <= 1'b0;
                tag[w] <= '0;
                dat[w] <= '0;
            end else if (flush) begin
                vld[w] <= 1'b0;
            end else if (fill_en && (rr == IDX_W'(w))) begin
                vld[w] <= 1'b1;
                tag[w] <= fill_vpn;
                dat[w] <= fill_ent;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rr <= '0;
        else if (flush)
            rr <= '0;
        else if (fill_en)
            rr <= (rr == IDX_W'(WAYS - 1)) ? '0 : rr + 1'b1;
    end

    always_comb begin
        hit     = |hit_vec;
        hit_ent = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_ent = hit_ent | dat[w];
    end

    // R10
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/page_guard.sv
module page_guard
    import pg_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 13,
    parameter int WAYS        = 8,
    parameter int ENTRY_BYTES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_super,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic              resp_cinh,
    input  logic              root_wr,
    input  logic [ADDR_W-1:0] root_wdata,
    output logic [ADDR_W-1:0] root_cur,
    output logic [ADDR_W-1:0] root_prev,
    output logic              map_rd_req,
    output logic [ADDR_W-1:0] map_rd_addr,
    input  logic              map_rd_valid,
    input  logic [4:0]        map_rd_data
);
    localparam int VPN_W = ADDR_W - PAGE_SHIFT;

    pg_state_e        state, state_nx;
    logic [VPN_W-1:0] q_vpn;
    logic [1:0]       q_kind;
    logic             q_sup;
    logic             drop;
    logic             hit, fill_en, fault;
    pte_t             hit_ent;

    logic unused_page_offset;
    assign unused_page_offset = ^req_addr[PAGE_SHIFT-1:0];

    pg_cache #(.VPN_W(VPN_W), .WAYS(WAYS)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (root_wr),
        .look_vpn (q_vpn),
        .hit      (hit),
        .hit_ent  (hit_ent),
        .fill_en  (fill_en),
        .fill_vpn (q_vpn),
        .fill_ent (pte_t'(map_rd_data))
    );

    pg_rule u_rule (
        .ent   (hit_ent),
        .kind  (q_kind),
        .sup   (q_sup),
        .fault (fault)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid)    state_nx = S_LOOK;
            S_LOOK:  state_nx = hit ? S_IDLE : S_WAIT;
            S_WAIT:  if (map_rd_valid) state_nx = S_LOOK;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state == S_IDLE);
        resp_valid = (state == S_LOOK) && hit;
        map_rd_req = (state == S_LOOK) && !hit;
        fill_en    = (state == S_WAIT) && map_rd_valid && !drop && !root_wr;
        resp_fault = fault;
        resp_cinh  = hit_ent.cinh;
        map_rd_addr = root_cur + ADDR_W'(q_vpn) * ADDR_W'(ENTRY_BYTES);
    end

    // request capture, root registers, stale-fill guard
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vpn     <= '0;
            q_kind    <= K_READ;
            q_sup     <= 1'b0;
            root_cur  <= '0;
            root_prev <= '0;
            drop      <= 1'b0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                q_vpn  <= req_addr[ADDR_W-1:PAGE_SHIFT];
                q_kind <= req_kind;
                q_sup  <= req_super;
            end
            if (root_wr) begin
                root_prev <= root_cur;
                root_cur  <= root_wdata;
            end
            if (state == S_WAIT && map_rd_valid)
                drop <= 1'b0;
            else if (root_wr && (state == S_WAIT || map_rd_req))
                drop <= 1'b1;
        end
    end

    // R8
    prev_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        root_wr |=> (root_prev == $past(root_cur)));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_rd_req |=> !req_ready);

    // R3
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && q_kind == K_WRITE && hit_ent.cls == C_PRRO) |-> resp_fault);

    // R5
    nx_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && q_kind == K_FETCH && hit_ent.nx) |-> resp_fault);

    // R4
    invalid_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && hit_ent.cls >= 3'd4) |-> resp_fault);
endmodule

// File: tb/page_guard_tb_top.sv
module page_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic        resp_valid, resp_fault, resp_cinh;
    logic        root_wr = 1'b0;
    logic [31:0] root_wdata = '0;
    logic [31:0] root_cur, root_prev;
    logic        map_rd_req;
    logic [31:0] map_rd_addr;
    logic        map_rd_valid = 1'b0;
    logic [4:0]  map_rd_data = '0;

    always #10 clk = ~clk;

    page_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_kind(req_kind), .req_super(req_super),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cinh(resp_cinh),
        .root_wr(root_wr), .root_wdata(root_wdata),
        .root_cur(root_cur), .root_prev(root_prev),
        .map_rd_req(map_rd_req), .map_rd_addr(map_rd_addr),
        .map_rd_valid(map_rd_valid), .map_rd_data(map_rd_data)
    );

    typedef struct packed {
        logic        f;
        logic        c;
        logic        hexp;
        logic [31:0] acc;
    } exp_t;

    exp_t        sq[$];
    string       tq[$];
    logic [4:0]  mm [logic [31:0]];
    logic [31:0] troot = '0;
    int          total = 0, bad = 0, nreads = 0, cyc = 0;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [4:0] ent_of(logic [31:0] a);
        if (mm.exists(a)) return mm[a];
        return 5'b00100;
    endfunction

    function automatic logic exp_fault(logic [4:0] e, logic [1:0] k, logic s);
        logic f;
        case (e[2:0])
            3'd0, 3'd1: f = 1'b0;
            3'd2:       f = !s;
            3'd3:       f = (k == 2'd1);
            default:    f = 1'b1;
        endcase
        if (k == 2'd2 && e[3]) f = 1'b1;
        return f;
    endfunction

    // map port responder: data two cycles after the request
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && map_rd_req) begin
                logic [31:0] a;
                a = map_rd_addr;
                nreads++;
                @(negedge clk);
                @(negedge clk);
                map_rd_valid = 1'b1;
                map_rd_data  = ent_of(a);
                @(negedge clk);
                map_rd_valid = 1'b0;
            end
        end
    end

    // monitor: pop expected item on each response
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && resp_valid) begin
                if (sq.size() == 0) begin
                    chk(0, "R11", "unexpected response", 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = sq.pop_front();
                    t = tq.pop_front();
                    chk(resp_fault == e.f, t, "fault", int'(resp_fault), int'(e.f));
                    chk(resp_cinh == e.c, "R6", "cinh", int'(resp_cinh), int'(e.c));
                    if (e.hexp)
                        chk(cyc - int'(e.acc) == 1, "R11", "hit latency",
                            cyc - int'(e.acc), 1);
                    else
                        chk(cyc - int'(e.acc) > 1, "R11", "miss latency",
                            cyc - int'(e.acc), 2);
                end
            end
        end
    end

    task automatic issue(int vpn, int off, logic [1:0] k, logic s, logic hexp, string tag);
        logic [4:0] e;
        exp_t       x;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e = ent_of(troot + 32'(vpn));
        x.f = exp_fault(e, k, s);
        x.c = e[4];
        x.hexp = hexp;
        x.acc = 32'(cyc);
        sq.push_back(x);
        tq.push_back(tag);
        req_valid = 1'b1;
        req_addr  = (32'(vpn) << 13) | 32'(off);
        req_kind  = k;
        req_super = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (sq.size() != 0 || !req_ready || map_rd_valid) @(negedge clk);
    endtask

    task automatic set_root(logic [31:0] r);
        logic [31:0] old;
        drain();
        old = troot;
        root_wr = 1'b1;
        root_wdata = r;
        @(negedge clk);
        root_wr = 1'b0;
        troot = r;
        chk(root_cur == r, "R8", "root_cur", int'(root_cur), int'(r));
        chk(root_prev == old, "R8", "root_prev", int'(root_prev), int'(old));
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R11", "no response after reset", int'(resp_valid), 0);
        chk(root_cur == 0, "R8", "root after reset", int'(root_cur), 0);

        // map of task A at 0x1000_0000, entry = {cinh, nx, cls}
        mm[32'h1000_0010] = 5'b0_0_000;
        mm[32'h1000_0011] = 5'b1_0_001;
        mm[32'h1000_0012] = 5'b0_0_010;
        mm[32'h1000_0013] = 5'b0_0_011;
        mm[32'h1000_0014] = 5'b1_0_100;
        mm[32'h1000_0015] = 5'b0_0_110;
        mm[32'h1000_0016] = 5'b0_1_000;
        set_root(32'h1000_0000);

        issue('h10, 0,      2'd0, 0, 0, "R1");
        issue('h10, 'h1fff, 2'd1, 0, 1, "R7");
        issue('h10, 'h0123, 2'd2, 0, 1, "R1");
        issue('h11, 0,      2'd1, 0, 0, "R1");
        issue('h12, 0,      2'd0, 0, 0, "R2");
        issue('h12, 0,      2'd0, 1, 1, "R2");
        issue('h13, 0,      2'd0, 0, 0, "R3");
        issue('h13, 0,      2'd1, 0, 1, "R3");
        issue('h13, 0,      2'd1, 1, 1, "R3");
        issue('h14, 0,      2'd0, 1, 0, "R4");
        issue('h15, 0,      2'd0, 1, 0, "R4");
        issue('h16, 0,      2'd0, 0, 0, "R5");
        issue('h16, 0,      2'd2, 0, 1, "R5");
        drain();
        chk(nreads == 7, "R10", "map reads task A", nreads, 7);

        // task B: page 0x10 invalid there
        mm[32'h2000_0010] = 5'b0_0_100;
        set_root(32'h2000_0000);
        issue('h10, 0, 2'd0, 0, 0, "R9");
        drain();
        chk(nreads == 8, "R9", "map read after switch", nreads, 8);

        // round-robin over 8 slots
        for (int p = 'h20; p <= 'h28; p++) mm[32'h2000_0000 + 32'(p)] = 5'b0_0_001;
        set_root(32'h2000_0000);
        base = nreads;
        for (int p = 'h20; p <= 'h27; p++) issue(p, 0, 2'd0, 0, 0, "R10");
        issue('h20, 0, 2'd0, 0, 1, "R10");
        drain();
        chk(nreads == base + 8, "R10", "eight fills", nreads, base + 8);
        issue('h28, 0, 2'd0, 0, 0, "R10");
        issue('h21, 0, 2'd0, 0, 1, "R10");
        issue('h20, 0, 2'd0, 0, 0, "R10");
        issue('h22, 0, 2'd0, 0, 1, "R10");
        drain();
        chk(nreads == base + 10, "R10", "round-robin evictions", nreads, base + 10);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule